// File: doc/BRIEF.md
# OTG Port Line-State Conditioner

This block sits between the pins of a dual-role USB port and the OTG controller. It brings the D+, D-, ID and VBUS pin levels into the clock domain through a synchronizer chain. From the synchronized levels it forms two merged signals for the controller: an ID level and a VBUS-valid level. Software can force either merged signal high or low through a two-bit override field. When VBUS is not forced, a select bit picks either the VBUS pin or a VBUS-valid value derived from the data lines. That derived value is high while both data lines are low.

Every edge of the synchronized VBUS, ID or data-line levels sets a sticky change flag. Software clears a flag by writing 1 to its bit. The flags combine with per-source enables and a global enable to form a single level interrupt. All state is reached through one 32-bit register with a write strobe and a continuous read value. Two bits of that register drive the pull-up enables for the ID pin and for the data lines.

Top module: `otg_line_cond`

## Requirements
- R1: After reset the register reads 0x40000000, and irq_o, both pull-up outputs and both merged outputs are 0.
- R2: The read-only bits show synchronized pin levels two clock edges after a pin changes: bit 29 is VBUS, bit 28 is ID, bit 27 is D- and bit 26 is D+. Bit 30 is the data-derived VBUS-valid, equal to NOT(D+ OR D-) of those synchronized levels.
- R3: The merged ID (bit 24 and merged_id_o) follows the force field at bits [15:14]. Code 11 gives 1, code 10 gives 0, and codes 00 and 01 pass the synchronized ID level through.
- R4: The merged VBUS (bit 25 and merged_vbus_o) follows the force field at bits [13:12] with the same codes as R3. When that field is 00 or 01, bit 10 selects the source: 0 selects the synchronized VBUS pin and 1 selects the data-derived value of bit 30.
- R5: Bit 6 (VBUS), bit 5 (ID) and bit 4 (D+ or D-) set on any rising or falling edge of the matching synchronized level. The flag is set one clock after the synchronized level changes.
- R6: Writing 1 to a bit in [6:4] clears that flag. Writing 0 to it leaves it unchanged. Writes to bits [30:24] have no effect.
- R7: If a flag is set by an edge and cleared by a write in the same cycle, the flag stays set.
- R8: irq_o = bit 3 AND ((bit 6 AND bit 2) OR (bit 5 AND bit 1) OR (bit 4 AND bit 0)).
- R9: Bits 17, 16, 15:12, 10 and 3:0 read back the last value written to them. Bit 17 drives id_pu_en_o and bit 16 drives dpdm_pu_en_o. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read value |
| dp_i | input | 1 | D+ pin level |
| dm_i | input | 1 | D- pin level |
| id_i | input | 1 | ID pin level |
| vbus_i | input | 1 | VBUS pin level |
| id_pu_en_o | output | 1 | ID pull-up enable |
| dpdm_pu_en_o | output | 1 | D+/D- pull-up enable |
| merged_id_o | output | 1 | Conditioned ID level |
| merged_vbus_o | output | 1 | Conditioned VBUS-valid level |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a write-1 clear that lands in the same cycle that a pin edge sets the flag. The bench first sets the flag with one pin edge. It then drives a second edge and counts the two synchronizer edges plus the edge-detect edge, so that the write strobe lines up exactly with the cycle the flag is set. A second corner is D+ and D- toggling together. The bench drives both in one cycle, so that a detector that XORs the two lines would miss the change.

// File: rtl/olc_pkg.sv
package olc_pkg;
  localparam int REG_W = 32;
  localparam int N_SRC = 3;    // change sources: vbus, id, dpdm
  localparam int N_PIN = 4;    // {vbus, id, dm, dp}

  // register bit positions
  localparam int B_DATA_VB = 30;
  localparam int B_VB_PIN  = 29;
  localparam int B_ID_PIN  = 28;
  localparam int B_DM      = 27;
  localparam int B_DP      = 26;
  localparam int B_MVB     = 25;
  localparam int B_MID     = 24;
  localparam int B_ID_PU   = 17;
  localparam int B_DPDM_PU = 16;
  localparam int B_FID_LO  = 14;
  localparam int B_FVB_LO  = 12;
  localparam int B_VB_SRC  = 10;
  localparam int B_FLAG_LO = 4;
  localparam int B_GEN     = 3;
  localparam int B_EN_LO   = 0;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_RSV  = 2'b01,
    FRC_LOW  = 2'b10,
    FRC_HIGH = 2'b11
  } force_e;

  typedef struct packed {
    logic       id_pu;
    logic       dpdm_pu;
    force_e     frc_id;
    force_e     frc_vb;
    logic       vb_src;
    logic       gen;
    logic [N_SRC-1:0] en;
  } cfg_t;
endpackage

// File: rtl/olc_sync.sv
module olc_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/olc_force.sv
module olc_force
  import olc_pkg::*;
(
  input  logic   ext_i,
  input  force_e frc_i,
  output logic   merged_o
);
  always_comb begin
    unique case (frc_i)
      FRC_LOW:  merged_o = 1'b0;
      FRC_HIGH: merged_o = 1'b1;
      default:  merged_o = ext_i;   // off and reserved code pass through
    endcase
  end
endmodule

// File: rtl/olc_flags.sv
module olc_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;   // set beats clear
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    assert_flag_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[g]) |-> $past(set_i[g]));
  end
endmodule

// File: rtl/otg_line_cond.sv
module otg_line_cond
  import olc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             dp_i,
  input  logic             dm_i,
  input  logic             id_i,
  input  logic             vbus_i,
  output logic             id_pu_en_o,
  output logic             dpdm_pu_en_o,
  output logic             merged_id_o,
  output logic             merged_vbus_o,
  output logic             irq_o
);
  localparam int P_DP = 0, P_DM = 1, P_ID = 2, P_VB = 3;

  logic [N_PIN-1:0] pin_s, pin_q, pin_e;
  logic [N_SRC-1:0] set_v, clr_v, flags;
  logic             data_vb, vb_ext;
  cfg_t             cfg;

  olc_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({vbus_i, id_i, dm_i, dp_i}), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_s;
  end
  assign pin_e = pin_s ^ pin_q;

  // flag order: [2] vbus, [1] id, [0] dp/dm
  assign set_v = {pin_e[P_VB], pin_e[P_ID], pin_e[P_DM] | pin_e[P_DP]};
  assign clr_v = wr_en_i ? wdata_i[B_FLAG_LO +: N_SRC] : '0;

  olc_flags #(.N(N_SRC)) u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg <= '{frc_id: FRC_OFF, frc_vb: FRC_OFF, en: '0, default: 1'b0};
    end else if (wr_en_i) begin
      cfg.id_pu   <= wdata_i[B_ID_PU];
      cfg.dpdm_pu <= wdata_i[B_DPDM_PU];
      cfg.frc_id  <= force_e'(wdata_i[B_FID_LO +: 2]);
      cfg.frc_vb  <= force_e'(wdata_i[B_FVB_LO +: 2]);
      cfg.vb_src  <= wdata_i[B_VB_SRC];
      cfg.gen     <= wdata_i[B_GEN];
      cfg.en      <= wdata_i[B_EN_LO +: N_SRC];
    end
  end

  assign data_vb = ~(pin_s[P_DP] | pin_s[P_DM]);
  assign vb_ext  = cfg.vb_src ? data_vb : pin_s[P_VB];

  olc_force u_frc_id (.ext_i(pin_s[P_ID]), .frc_i(cfg.frc_id), .merged_o(merged_id_o));
  olc_force u_frc_vb (.ext_i(vb_ext),      .frc_i(cfg.frc_vb), .merged_o(merged_vbus_o));

  assign irq_o        = cfg.gen & |(flags & cfg.en);
  assign id_pu_en_o   = cfg.id_pu;
  assign dpdm_pu_en_o = cfg.dpdm_pu;

  always_comb begin
    rdata_o                          = '0;
    rdata_o[B_DATA_VB]               = data_vb;
    rdata_o[B_VB_PIN]                = pin_s[P_VB];
    rdata_o[B_ID_PIN]                = pin_s[P_ID];
    rdata_o[B_DM]                    = pin_s[P_DM];
    rdata_o[B_DP]                    = pin_s[P_DP];
    rdata_o[B_MVB]                   = merged_vbus_o;
    rdata_o[B_MID]                   = merged_id_o;
    rdata_o[B_ID_PU]                 = cfg.id_pu;
    rdata_o[B_DPDM_PU]               = cfg.dpdm_pu;
    rdata_o[B_FID_LO +: 2]           = cfg.frc_id;
    rdata_o[B_FVB_LO +: 2]           = cfg.frc_vb;
    rdata_o[B_VB_SRC]                = cfg.vb_src;
    rdata_o[B_FLAG_LO +: N_SRC]      = flags;
    rdata_o[B_GEN]                   = cfg.gen;
    rdata_o[B_EN_LO +: N_SRC]        = cfg.en;
  end

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[B_GEN] |-> !irq_o);
  assert_force_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[B_FID_LO +: 2] == 2'b11) |-> merged_id_o);
  assert_force_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[B_FVB_LO +: 2] == 2'b10) |-> !merged_vbus_o);
  assert_edge_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_s[P_ID] != $past(pin_s[P_ID])) |=> rdata_o[B_FLAG_LO + 1]);
endmodule

// File: tb/sim_otg_line_cond.sv
module sim_otg_line_cond;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic        p_dp = 0, p_dm = 0, p_id = 0, p_vb = 0;
  logic [31:0] rdata;
  logic        id_pu, dpdm_pu, m_id, m_vb, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;   // 250 MHz

  otg_line_cond u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr), .wdata_i(wd), .rdata_o(rdata),
    .dp_i(p_dp), .dm_i(p_dm), .id_i(p_id), .vbus_i(p_vb),
    .id_pu_en_o(id_pu), .dpdm_pu_en_o(dpdm_pu),
    .merged_id_o(m_id), .merged_vbus_o(m_vb), .irq_o(irq)
  );

  // reference model: pin history queue, flags and config as plain variables
  logic [3:0] hist[$];      // [0] newest sample; bits {vb,id,dm,dp}
  logic [2:0] m_flags = '0; // {vbus,id,dpdm}
  logic [31:0] m_cfg = '0;  // writable bits only
  localparam logic [31:0] CFG_MASK = 32'h0003_F40F;

  initial hist = '{4'h0, 4'h0, 4'h0, 4'h0};

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{4'h0, 4'h0, 4'h0, 4'h0};
      m_flags = '0;
      m_cfg = '0;
    end else begin
      logic [3:0] d;
      logic [2:0] s, c;
      d = hist[1] ^ hist[2];
      s = {d[3], d[2], d[1] | d[0]};
      c = wr ? wd[6:4] : 3'b000;
      m_flags = (m_flags & ~c) | s;
      if (wr) m_cfg = wd & CFG_MASK;
      hist.push_front({p_vb, p_id, p_dm, p_dp});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic fsel(logic [1:0] f, logic ext);
    return f[1] ? f[0] : ext;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [3:0] s;
    logic dv, e_mid, e_mvb;
    s = hist[1];
    dv = ~(s[0] | s[1]);
    e_mid = fsel(m_cfg[15:14], s[2]);
    e_mvb = fsel(m_cfg[13:12], m_cfg[10] ? dv : s[3]);
    cyc++;
    chk("R2 pin status", {27'd0, dv, s}, {27'd0, rdata[30:26]});
    chk("R3 merged id", {30'd0, rdata[24], m_id}, {30'd0, e_mid, e_mid});
    chk("R4 merged vbus", {30'd0, rdata[25], m_vb}, {30'd0, e_mvb, e_mvb});
    chk("R5 flags", {29'd0, rdata[6:4]}, {29'd0, m_flags});
    chk("R8 irq", {31'd0, irq},
        {31'd0, m_cfg[3] & |(m_flags & m_cfg[2:0])});
    chk("R9 cfg readback", rdata & 32'h8003_FF8F, m_cfg);
    chk("R9 pull-ups", {30'd0, id_pu, dpdm_pu}, {30'd0, m_cfg[17], m_cfg[16]});
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=timeout exp=done");
    summary();
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wreg(logic [31:0] v);
    wr = 1'b1; wd = v;
    tick(1);
    wr = 1'b0; wd = '0;
  endtask

  function automatic logic [31:0] cfgw(logic ipu, logic dpu, logic [1:0] fid,
      logic [1:0] fvb, logic src, logic gen, logic [2:0] en);
    return {14'd0, ipu, dpu, fid, fvb, 1'b0, src, 6'd0, gen, en};
  endfunction

  initial begin
    tick(3);
    // R1: reset value
    chk("R1 reset rdata", rdata, 32'h4000_0000);
    chk("R1 reset outs", {27'd0, irq, id_pu, dpdm_pu, m_id, m_vb}, 32'd0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 after release", rdata, 32'h4000_0000);

    // R9: pull-ups and config readback
    wreg(cfgw(1, 1, 0, 0, 0, 0, 3'b000));
    chk("R9 pu outputs", {30'd0, id_pu, dpdm_pu}, 32'd3);

    // R2, R5: D+ rises
    p_dp = 1; tick(2);
    chk("R2 dp sync after 2 edges", {30'd0, rdata[30], rdata[26]}, 32'd1);
    tick(1);
    chk("R5 dpdm flag", {31'd0, rdata[4]}, 32'd1);

    // R6: write 0 keeps, write 1 clears, read-only bits ignored
    wreg(cfgw(1, 1, 0, 0, 0, 0, 3'b000) | 32'h7F00_0000);
    chk("R6 w0 keeps flag", {31'd0, rdata[4]}, 32'd1);
    chk("R6 ro bits ignore write", rdata[30:24], 7'b0000100);
    wreg(cfgw(1, 1, 0, 0, 0, 0, 3'b000) | 32'h10);
    chk("R6 w1 clears flag", {31'd0, rdata[4]}, 32'd0);

    // R5, R8: id and vbus edges with interrupt enables
    p_id = 1; p_vb = 1; tick(4);
    chk("R5 id and vbus flags", {29'd0, rdata[6:4]}, 32'd6);
    wreg(cfgw(0, 0, 0, 0, 0, 0, 3'b110));
    chk("R8 no global enable", {31'd0, irq}, 32'd0);
    wreg(cfgw(0, 0, 0, 0, 0, 1, 3'b001));
    chk("R8 flag not enabled", {31'd0, irq}, 32'd0);
    wreg(cfgw(0, 0, 0, 0, 0, 1, 3'b010));
    chk("R8 id source", {31'd0, irq}, 32'd1);
    wreg(cfgw(0, 0, 0, 0, 0, 1, 3'b010) | 32'h20);
    chk("R8 cleared drops irq", {31'd0, irq}, 32'd0);

    // R3: id force codes with pin high then low
    wreg(cfgw(0, 0, 2'b10, 0, 0, 0, 0));
    chk("R3 force low", {31'd0, m_id}, 32'd0);
    p_id = 0; tick(3);
    wreg(cfgw(0, 0, 2'b11, 0, 0, 0, 0));
    chk("R3 force high", {31'd0, m_id}, 32'd1);
    wreg(cfgw(0, 0, 2'b01, 0, 0, 0, 0));
    chk("R3 reserved passes pin", {31'd0, m_id}, 32'd0);
    wreg(cfgw(0, 0, 2'b00, 0, 0, 0, 0));
    chk("R3 off passes pin", {31'd0, m_id}, 32'd0);

    // R4: vbus source select and force
    chk("R4 pin source", {31'd0, m_vb}, 32'd1);
    wreg(cfgw(0, 0, 0, 0, 1, 0, 0));
    chk("R4 data source dp high", {31'd0, m_vb}, 32'd0);
    p_dp = 0; tick(3);
    chk("R4 data source idle lines", {31'd0, m_vb}, 32'd1);
    wreg(cfgw(0, 0, 0, 2'b10, 1, 0, 0));
    chk("R4 force low", {31'd0, m_vb}, 32'd0);
    p_vb = 0; tick(3);
    wreg(cfgw(0, 0, 0, 2'b11, 0, 0, 0));
    chk("R4 force high", {31'd0, m_vb}, 32'd1);
    wreg(cfgw(0, 0, 0, 2'b01, 0, 0, 0));
    chk("R4 reserved passes pin", {31'd0, m_vb}, 32'd0);

    // clear all flags, then R7 set-vs-clear collision
    wreg(32'h70);
    tick(1);
    p_id = 1; tick(4);
    chk("R7 setup flag", {31'd0, rdata[5]}, 32'd1);
    p_id = 0;
    tick(2);                 // two sync edges done; next edge sets flag
    wreg(32'h20);            // clear in the same cycle
    chk("R7 set wins", {31'd0, rdata[5]}, 32'd1);
    wreg(32'h20);
    chk("R7 later clear works", {31'd0, rdata[5]}, 32'd0);

    // R5: D+ and D- toggle together
    p_dp = 1; p_dm = 1; tick(4);
    chk("R5 both lines flag", {31'd0, rdata[4]}, 32'd1);
    chk("R2 both lines", {27'd0, rdata[30:26]}, 32'h03);

    tick(5);
    summary();
  end
endmodule